// File: doc/BRIEF.md
# Processor Run-Control Debug Co-Processor

This block sits between a host command channel and a small multi-cycle processor core. The host sends commands one at a time over a valid/ready channel. Each command carries a 4-bit opcode, a 32-bit byte address and a 32-bit payload. Some commands reach the instruction memory and the data memory. Others control the core.

Starting a program takes three commands in a fixed order. First, a start address goes into a staging argument register. Second, a separate command copies that register into the core's program counter. Third, a start command runs the core in one of two ways: until the core reports its halt instruction, or for a stated number of clock cycles. At the end of either run the block raises a one-cycle completion interrupt. While the core runs, two saturating counters record enabled cycles and retired instructions, and the host can read both at any time.

Every command gets exactly one response. A response holds a 32-bit data word, a 4-bit kind code and the 32-bit address that was sent with the command.

The command side is a three-state machine:
- `CS_IDLE`: accepts a command.
  - A memory read goes to `CS_MEM_WAIT`.
  - Every other command goes straight to `CS_RESP`.
- `CS_MEM_WAIT`: captures the memory word one cycle after the read strobe, then goes to `CS_RESP`.
- `CS_RESP`: holds the response until the host takes it, then returns to `CS_IDLE`.

The run side is also a three-state machine:
- `RS_IDLE`: the core is stopped.
  - An until-halt start goes to `RS_FREE`.
  - A bounded start with a non-zero count goes to `RS_COUNT`.
  - A bounded start with a count of zero stays here and signals completion.
- `RS_FREE`: returns to `RS_IDLE` on a halt (with interrupt) or on a stop command (no interrupt).
- `RS_COUNT`: returns to `RS_IDLE` on a halt or when the count runs out (both with interrupt), or on a stop command (no interrupt).

Top module: `run_ctl_cop`

## Requirements
- R1: Opcode 1 writes `cmd_data` to the instruction memory at byte address `cmd_addr` and answers with kind 2. Opcode 2 reads that word and answers with kind 1, the word in `rsp_data` and the address in `rsp_addr`.
- R2: Opcodes 3 (write) and 4 (read) do the same on the data memory. The data memory is a separate space from the instruction memory.
- R3: Opcode 5 stores `cmd_data` in the argument register without touching the core. Opcode 6 raises `core_pc_load` for one cycle, with `core_pc_value` equal to the argument register.
- R4: Opcode 7 holds `core_run` high from the cycle after acceptance through the cycle in which `core_halt` is seen. In the next cycle, `irq_done` is high for exactly one cycle while `core_run` is low.
- R5: Opcode 8 with a non-zero count N in `cmd_data` holds `core_run` high for exactly N consecutive cycles, then pulses `irq_done` once.
- R6: Opcode 8 with a count of zero never raises `core_run` and pulses `irq_done` once.
- R7: Opcode 9 drops `core_run` in the cycle after acceptance and raises no interrupt.
- R8: Counter behaviour:
  - Opcode 10 returns the number of `core_run` cycles and opcode 11 returns the number of cycles with both `core_run` and `core_retire` high, each with kind 4.
  - Both counters clear when a start is accepted.
  - Both counters hold their value while the core is stopped.
- R9: Each counter saturates at 2^CNT_W-1 and does not wrap.
- R10: While `core_run` is high, the following commands answer with kind 3 and produce no strobe:
  - memory commands (opcodes 1 to 4), which raise no memory strobe;
  - start commands (opcodes 7 and 8) and the program-counter copy (opcode 6), which do not pulse `core_pc_load`.
- R11: One command at a time: `cmd_ready` is low from acceptance until the response is taken. While `rsp_valid` is high and `rsp_ready` is low, the response fields stay unchanged.
- R12: Any opcode outside 1 to 11 answers with kind 3 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | 32 | Byte address of the command |
| cmd_data | input | 32 | Command payload |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 32 | Response data word |
| rsp_type | output | 4 | Response kind: 1 memory data, 2 ack, 3 error, 4 counter |
| rsp_addr | output | 32 | Address echoed from the command |
| imem_req | output | 1 | Instruction memory strobe |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | 32 | Instruction memory byte address |
| imem_wdata | output | 32 | Instruction memory write data |
| imem_rdata | input | 32 | Instruction memory read data, one cycle after the strobe |
| dmem_req | output | 1 | Data memory strobe |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_wdata | output | 32 | Data memory write data |
| dmem_rdata | input | 32 | Data memory read data, one cycle after the strobe |
| core_run | output | 1 | Core enable |
| core_pc_load | output | 1 | Program counter load strobe |
| core_pc_value | output | 32 | Program counter load value |
| core_retire | input | 1 | One-cycle pulse per retired instruction |
| core_halt | input | 1 | Core executed its halt instruction |
| irq_done | output | 1 | One-cycle completion interrupt |

## Verification
The assertions check several properties on every cycle:
- the response stays stable under back-pressure;
- `cmd_ready` is low while a response is pending;
- there is no memory strobe while the core runs;
- no program-counter load happens while the core runs;
- the interrupt is a single-cycle pulse with the core stopped;
- the counters hold at their ceiling and freeze while the core is idle.

Only the bench's scenarios can show the rest:
- exact run lengths for until-halt, bounded and zero-count starts;
- counter values after each run;
- separation of the two memories;
- the staging order of argument, program-counter load and start;
- the error kinds returned for commands refused while the core is busy.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    typedef enum logic [3:0] {
        OP_IMEM_WR  = 4'd1,
        OP_IMEM_RD  = 4'd2,
        OP_DMEM_WR  = 4'd3,
        OP_DMEM_RD  = 4'd4,
        OP_ARG_SET  = 4'd5,
        OP_PC_SET   = 4'd6,
        OP_RUN_HALT = 4'd7,
        OP_RUN_N    = 4'd8,
        OP_STOP     = 4'd9,
        OP_CYC_RD   = 4'd10,
        OP_INS_RD   = 4'd11
    } cmd_op_e;

    typedef enum logic [3:0] {
        RSP_MEM = 4'd1,
        RSP_ACK = 4'd2,
        RSP_ERR = 4'd3,
        RSP_CNT = 4'd4
    } rsp_kind_e;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_MEM_WAIT,
        CS_RESP
    } cmd_state_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_FREE,
        RS_COUNT
    } run_state_e;

endpackage

// File: rtl/rcc_sat_counter.sv
module rcc_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CEIL = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CEIL)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/rcc_run_ctrl.sv
module rcc_run_ctrl
    import rcc_pkg::*;
#(
    parameter int BOUND_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_free,
    input  logic               go_bound,
    input  logic [BOUND_W-1:0] bound_n,
    input  logic               stop_req,
    input  logic               core_halt,
    output logic               core_run,
    output logic               done_pulse
);
    localparam logic [BOUND_W-1:0] ONE = BOUND_W'(1);

    run_state_e         rs_q, rs_d;
    logic [BOUND_W-1:0] remain_q, remain_d;
    logic               fin_d, done_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q     <= RS_IDLE;
            remain_q <= '0;
            done_q   <= 1'b0;
        end else begin
            rs_q     <= rs_d;
            remain_q <= remain_d;
            done_q   <= fin_d;
        end
    end

    // next state and outputs
    always_comb begin
        rs_d     = rs_q;
        remain_d = remain_q;
        fin_d    = 1'b0;
        unique case (rs_q)
            RS_IDLE: begin
                if (go_free) begin
                    rs_d = RS_FREE;
                end else if (go_bound) begin
                    if (bound_n == '0) begin
                        fin_d = 1'b1;
                    end else begin
                        rs_d     = RS_COUNT;
                        remain_d = bound_n;
                    end
                end
            end
            RS_FREE: begin
                if (core_halt) begin
                    rs_d  = RS_IDLE;
                    fin_d = 1'b1;
                end else if (stop_req) begin
                    rs_d = RS_IDLE;
                end
            end
            RS_COUNT: begin
                remain_d = remain_q - ONE;
                if (core_halt || (remain_q == ONE)) begin
                    rs_d  = RS_IDLE;
                    fin_d = 1'b1;
                end else if (stop_req) begin
                    rs_d = RS_IDLE;
                end
            end
            default: rs_d = RS_IDLE;
        endcase
    end

    assign core_run   = (rs_q != RS_IDLE);
    assign done_pulse = done_q;
endmodule

// File: rtl/run_ctl_cop.sv
module run_ctl_cop
    import rcc_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int BOUND_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [3:0]  cmd_op,
    input  logic [31:0] cmd_addr,
    input  logic [31:0] cmd_data,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_data,
    output logic [3:0]  rsp_type,
    output logic [31:0] rsp_addr,
    output logic        imem_req,
    output logic        imem_we,
    output logic [31:0] imem_addr,
    output logic [31:0] imem_wdata,
    input  logic [31:0] imem_rdata,
    output logic        dmem_req,
    output logic        dmem_we,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    input  logic [31:0] dmem_rdata,
    output logic        core_run,
    output logic        core_pc_load,
    output logic [31:0] core_pc_value,
    input  logic        core_retire,
    input  logic        core_halt,
    output logic        irq_done
);
    localparam int WORD_W = 32;
    localparam int N_CNT  = 2;

    cmd_state_e        cs_q, cs_d;
    rsp_kind_e         kind_q, kind_d;
    logic [WORD_W-1:0] word_q, word_d;
    logic [WORD_W-1:0] addr_q;
    logic [WORD_W-1:0] arg_q;
    logic              rd_dmem_q, rd_dmem_d;
    logic              arg_we;
    logic              go_free, go_bound, stop_req;
    logic              cnt_clr;
    logic [N_CNT-1:0]  cnt_inc;
    logic [CNT_W-1:0]  cnt_val [N_CNT];
    logic [CNT_W-1:0]  cyc_cnt, ins_cnt;
    logic              accept;

    assign cmd_ready = (cs_q == CS_IDLE);
    assign accept    = cmd_ready && cmd_valid;

    // run controller
    rcc_run_ctrl #(.BOUND_W(BOUND_W)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_free    (go_free),
        .go_bound   (go_bound),
        .bound_n    (cmd_data[BOUND_W-1:0]),
        .stop_req   (stop_req),
        .core_halt  (core_halt),
        .core_run   (core_run),
        .done_pulse (irq_done)
    );

    // cycle and retired-instruction counters
    assign cnt_clr    = go_free | go_bound;
    assign cnt_inc[0] = core_run;
    assign cnt_inc[1] = core_run & core_retire;

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        rcc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (cnt_inc[g]),
            .count (cnt_val[g])
        );
    end

    assign cyc_cnt = cnt_val[0];
    assign ins_cnt = cnt_val[1];

    // memory address and data follow the command fields
    assign imem_addr     = cmd_addr;
    assign imem_wdata    = cmd_data;
    assign dmem_addr     = cmd_addr;
    assign dmem_wdata    = cmd_data;
    assign core_pc_value = arg_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= CS_IDLE;
        end else begin
            cs_q <= cs_d;
        end
    end

    // response, argument and read-select registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= RSP_ACK;
            word_q    <= '0;
            addr_q    <= '0;
            arg_q     <= '0;
            rd_dmem_q <= 1'b0;
        end else begin
            if (accept) begin
                kind_q    <= kind_d;
                word_q    <= word_d;
                addr_q    <= cmd_addr;
                rd_dmem_q <= rd_dmem_d;
            end else if (cs_q == CS_MEM_WAIT) begin
                word_q <= rd_dmem_q ? dmem_rdata : imem_rdata;
            end
            if (arg_we) begin
                arg_q <= cmd_data;
            end
        end
    end

    // command decode and next state
    always_comb begin
        cs_d         = cs_q;
        kind_d       = RSP_ACK;
        word_d       = '0;
        rd_dmem_d    = 1'b0;
        imem_req     = 1'b0;
        imem_we      = 1'b0;
        dmem_req     = 1'b0;
        dmem_we      = 1'b0;
        core_pc_load = 1'b0;
        arg_we       = 1'b0;
        go_free      = 1'b0;
        go_bound     = 1'b0;
        stop_req     = 1'b0;
        unique case (cs_q)
            CS_IDLE: begin
                if (cmd_valid) begin
                    cs_d = CS_RESP;
                    unique case (cmd_op_e'(cmd_op))
                        OP_IMEM_WR, OP_DMEM_WR: begin
                            if (core_run) begin
                                kind_d = RSP_ERR;
                            end else begin
                                imem_req = (cmd_op_e'(cmd_op) == OP_IMEM_WR);
                                imem_we  = imem_req;
                                dmem_req = !imem_req;
                                dmem_we  = dmem_req;
                            end
                        end
                        OP_IMEM_RD, OP_DMEM_RD: begin
                            if (core_run) begin
                                kind_d = RSP_ERR;
                            end else begin
                                kind_d    = RSP_MEM;
                                rd_dmem_d = (cmd_op_e'(cmd_op) == OP_DMEM_RD);
                                imem_req  = !rd_dmem_d;
                                dmem_req  = rd_dmem_d;
                                cs_d      = CS_MEM_WAIT;
                            end
                        end
                        OP_ARG_SET: arg_we = 1'b1;
                        OP_PC_SET: begin
                            if (core_run) kind_d = RSP_ERR;
                            else          core_pc_load = 1'b1;
                        end
                        OP_RUN_HALT: begin
                            if (core_run) kind_d = RSP_ERR;
                            else          go_free = 1'b1;
                        end
                        OP_RUN_N: begin
                            if (core_run) kind_d = RSP_ERR;
                            else          go_bound = 1'b1;
                        end
                        OP_STOP: stop_req = 1'b1;
                        OP_CYC_RD: begin
                            kind_d              = RSP_CNT;
                            word_d[CNT_W-1:0]   = cyc_cnt;
                        end
                        OP_INS_RD: begin
                            kind_d              = RSP_CNT;
                            word_d[CNT_W-1:0]   = ins_cnt;
                        end
                        default: kind_d = RSP_ERR;
                    endcase
                end
            end
            CS_MEM_WAIT: cs_d = CS_RESP;
            CS_RESP: begin
                if (rsp_ready) cs_d = CS_IDLE;
            end
            default: cs_d = CS_IDLE;
        endcase
    end

    assign rsp_valid = (cs_q == CS_RESP);
    assign rsp_data  = word_q;
    assign rsp_type  = kind_q;
    assign rsp_addr  = addr_q;
endmodule

// File: rtl/run_ctl_cop_chk.sv
module run_ctl_cop_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [31:0]      rsp_data,
    input logic [3:0]       rsp_type,
    input logic [31:0]      rsp_addr,
    input logic             core_run,
    input logic             irq_done,
    input logic             imem_req,
    input logic             dmem_req,
    input logic             core_pc_load,
    input logic [CNT_W-1:0] cyc_cnt,
    input logic [CNT_W-1:0] ins_cnt,
    input logic             cnt_clr
);
    localparam logic [CNT_W-1:0] CEIL = {CNT_W{1'b1}};

    // R11
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)
                                       && $stable(rsp_type) && $stable(rsp_addr)));

    // R11
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    // R10
    no_mem_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_run |-> !(imem_req || dmem_req));

    // R3
    pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_pc_load |-> !core_run);

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    // R4
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> !core_run);

    // R9
    cyc_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && cyc_cnt == CEIL) |=> (cyc_cnt == CEIL));

    // R9
    ins_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && ins_cnt == CEIL) |=> (ins_cnt == CEIL));

    // R8
    cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !core_run) |=> $stable(cyc_cnt));
endmodule

bind run_ctl_cop run_ctl_cop_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_ready    (cmd_ready),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .rsp_type     (rsp_type),
    .rsp_addr     (rsp_addr),
    .core_run     (core_run),
    .irq_done     (irq_done),
    .imem_req     (imem_req),
    .dmem_req     (dmem_req),
    .core_pc_load (core_pc_load),
    .cyc_cnt      (cyc_cnt),
    .ins_cnt      (ins_cnt),
    .cnt_clr      (cnt_clr)
);

// File: tb/run_ctl_cop_tb.sv
`timescale 1ns/1ps
module run_ctl_cop_tb;
    localparam int CW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [3:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data, rsp_addr;
    logic [3:0]  rsp_type;
    logic        imem_req, imem_we, dmem_req, dmem_we;
    logic [31:0] imem_addr, imem_wdata, dmem_addr, dmem_wdata;
    logic [31:0] imem_rdata, dmem_rdata;
    logic        core_run, core_pc_load, core_retire, core_halt, irq_done;
    logic [31:0] core_pc_value;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    run_ctl_cop #(.CNT_W(CW), .BOUND_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_type(rsp_type), .rsp_addr(rsp_addr),
        .imem_req(imem_req), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .imem_rdata(imem_rdata),
        .dmem_req(dmem_req), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
        .core_run(core_run), .core_pc_load(core_pc_load),
        .core_pc_value(core_pc_value), .core_retire(core_retire),
        .core_halt(core_halt), .irq_done(irq_done)
    );

    // memory models, one-cycle read latency
    logic [31:0] imem [64];
    logic [31:0] dmem [64];
    int mem_strobes = 0;
    always @(posedge clk) begin
        if (imem_req) begin
            if (imem_we) imem[imem_addr[7:2]] <= imem_wdata;
            imem_rdata <= imem[imem_addr[7:2]];
        end
        if (dmem_req) begin
            if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
            dmem_rdata <= dmem[dmem_addr[7:2]];
        end
        if (imem_req || dmem_req) mem_strobes <= mem_strobes + 1;
    end

    // core model: retires on even run cycles, halts after halt_at cycles
    int  run_cnt = 0;
    int  halt_at = 0;
    bit  halt_en = 1'b0;
    assign core_retire = core_run && (run_cnt % 2 == 0);
    assign core_halt   = core_run && halt_en && (run_cnt == halt_at - 1);

    int run_seen = 0;
    int irq_seen = 0;
    int pcl_seen = 0;
    logic [31:0] pcl_val = '0;
    always @(posedge clk) begin
        if (core_pc_load) begin
            run_cnt  <= 0;
            pcl_seen <= pcl_seen + 1;
            pcl_val  <= core_pc_value;
        end else if (core_run) begin
            run_cnt <= run_cnt + 1;
        end
        if (core_run) run_seen <= run_seen + 1;
        if (irq_done) irq_seen <= irq_seen + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [3:0] op, input logic [31:0] a, input logic [31:0] d,
                          input int hold, output logic [31:0] rd, output logic [3:0] rt,
                          output logic [31:0] ra);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        @(negedge clk);
        for (int w = 0; w < 50 && !rsp_valid; w++) @(negedge clk);
        rd = rsp_data; rt = rsp_type; ra = rsp_addr;
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            chk("R11 response stable under back-pressure",
                {rsp_data[27:0] ^ rd[27:0], rsp_type ^ rt}, 32'h0);
            chk("R11 cmd_ready low while response pending", {31'b0, cmd_ready}, 32'h0);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        #1 rsp_ready = 1'b0;
    endtask

    task automatic wait_irq(input int base);
        for (int w = 0; w < 500 && irq_seen == base; w++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    logic [31:0] rd, ra;
    logic [3:0]  rt;

    task automatic t_reset();
        @(negedge clk);
        chk("R11 cmd_ready after reset", {31'b0, cmd_ready}, 32'h1);
        chk("R4 core_run and irq low after reset", {30'b0, core_run, irq_done}, 32'h0);
        chk("R11 no response after reset", {31'b0, rsp_valid}, 32'h0);
    endtask

    task automatic t_imem();
        do_cmd(4'd1, 32'h10, 32'hA5A5_0001, 0, rd, rt, ra);
        chk("R1 write ack kind", {28'b0, rt}, 32'h2);
        do_cmd(4'd1, 32'h14, 32'h1234_5678, 0, rd, rt, ra);
        do_cmd(4'd2, 32'h10, 32'h0, 3, rd, rt, ra);
        chk("R1 read data", rd, 32'hA5A5_0001);
        chk("R1 read kind", {28'b0, rt}, 32'h1);
        chk("R1 read address echo", ra, 32'h10);
        do_cmd(4'd2, 32'h14, 32'h0, 0, rd, rt, ra);
        chk("R1 second word", rd, 32'h1234_5678);
    endtask

    task automatic t_dmem();
        do_cmd(4'd3, 32'h10, 32'hDEAD_0010, 0, rd, rt, ra);
        chk("R2 write ack kind", {28'b0, rt}, 32'h2);
        do_cmd(4'd4, 32'h10, 32'h0, 0, rd, rt, ra);
        chk("R2 data memory read", rd, 32'hDEAD_0010);
        chk("R2 read kind", {28'b0, rt}, 32'h1);
        do_cmd(4'd2, 32'h10, 32'h0, 0, rd, rt, ra);
        chk("R2 instruction memory untouched", rd, 32'hA5A5_0001);
    endtask

    task automatic t_pc();
        int base;
        base = pcl_seen;
        do_cmd(4'd5, 32'h0, 32'h0000_0040, 0, rd, rt, ra);
        chk("R3 argument load does not touch core", pcl_seen - base, 32'h0);
        do_cmd(4'd6, 32'h0, 32'h0, 0, rd, rt, ra);
        chk("R3 single pc load pulse", pcl_seen - base, 32'h1);
        chk("R3 pc load value", pcl_val, 32'h40);
    endtask

    task automatic start_run(input logic [3:0] op, input logic [31:0] n);
        do_cmd(4'd6, 32'h0, 32'h0, 0, rd, rt, ra);
        do_cmd(op, 32'h0, n, 0, rd, rt, ra);
    endtask

    task automatic read_counters(input string req, input int ecyc, input int eins);
        do_cmd(4'd10, 32'h0, 32'h0, 0, rd, rt, ra);
        chk({req, " cycle count"}, rd, ecyc);
        chk("R8 counter kind", {28'b0, rt}, 32'h4);
        do_cmd(4'd11, 32'h0, 32'h0, 0, rd, rt, ra);
        chk({req, " instruction count"}, rd, eins);
    endtask

    task automatic t_run_halt();
        int rb, ib;
        halt_en = 1'b1; halt_at = 10;
        rb = run_seen; ib = irq_seen;
        start_run(4'd7, 32'h0);
        wait_irq(ib);
        chk("R4 run length until halt", run_seen - rb, 32'd10);
        chk("R4 one interrupt", irq_seen - ib, 32'd1);
        read_counters("R8", 10, 5);
        halt_en = 1'b0;
    endtask

    task automatic t_bound();
        int rb, ib;
        rb = run_seen; ib = irq_seen;
        start_run(4'd8, 32'd7);
        wait_irq(ib);
        chk("R5 bounded run length", run_seen - rb, 32'd7);
        chk("R5 one interrupt", irq_seen - ib, 32'd1);
        read_counters("R8", 7, 4);
    endtask

    task automatic t_zero();
        int rb, ib;
        rb = run_seen; ib = irq_seen;
        start_run(4'd8, 32'd0);
        wait_irq(ib);
        chk("R6 zero count never runs", run_seen - rb, 32'd0);
        chk("R6 zero count interrupt", irq_seen - ib, 32'd1);
        read_counters("R6", 0, 0);
    endtask

    task automatic t_sat();
        int ib;
        ib = irq_seen;
        start_run(4'd8, 32'd100);
        wait_irq(ib);
        read_counters("R9", 63, 50);
    endtask

    task automatic t_busy_stop();
        int ib, sb, pb;
        logic [31:0] c1;
        ib = irq_seen;
        start_run(4'd7, 32'h0);
        repeat (4) @(negedge clk);
        sb = mem_strobes; pb = pcl_seen;
        do_cmd(4'd1, 32'h10, 32'hBAD0_BAD0, 0, rd, rt, ra);
        chk("R10 memory write refused", {28'b0, rt}, 32'h3);
        do_cmd(4'd4, 32'h10, 32'h0, 0, rd, rt, ra);
        chk("R10 memory read refused", {28'b0, rt}, 32'h3);
        chk("R10 no memory strobe while running", mem_strobes - sb, 32'd0);
        do_cmd(4'd8, 32'h0, 32'd3, 0, rd, rt, ra);
        chk("R10 start refused while running", {28'b0, rt}, 32'h3);
        do_cmd(4'd6, 32'h0, 32'h0, 0, rd, rt, ra);
        chk("R10 pc load refused", {28'b0, rt}, 32'h3);
        chk("R10 no pc load pulse", pcl_seen - pb, 32'd0);
        do_cmd(4'd9, 32'h0, 32'h0, 0, rd, rt, ra);
        chk("R7 stop ack", {28'b0, rt}, 32'h2);
        @(negedge clk);
        chk("R7 core stopped", {31'b0, core_run}, 32'h0);
        do_cmd(4'd10, 32'h0, 32'h0, 0, c1, rt, ra);
        repeat (8) @(negedge clk);
        do_cmd(4'd10, 32'h0, 32'h0, 0, rd, rt, ra);
        chk("R8 counter frozen after stop", rd, c1);
        chk("R7 no interrupt on stop", irq_seen - ib, 32'd0);
        do_cmd(4'd2, 32'h10, 32'h0, 0, rd, rt, ra);
        chk("R10 refused write left memory intact", rd, 32'hA5A5_0001);
    endtask

    task automatic t_bad_op();
        int sb;
        sb = mem_strobes;
        do_cmd(4'd15, 32'h10, 32'h0, 0, rd, rt, ra);
        chk("R12 unknown opcode error", {28'b0, rt}, 32'h3);
        do_cmd(4'd0, 32'h10, 32'h0, 0, rd, rt, ra);
        chk("R12 opcode zero error", {28'b0, rt}, 32'h3);
        chk("R12 no side effect", mem_strobes - sb, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_imem();
        t_dmem();
        t_pc();
        t_run_halt();
        t_bound();
        t_zero();
        t_sat();
        t_busy_stop();
        t_bad_op();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule